// File: doc/BRIEF.md
# Three-Level Priority Interrupt Controller

This block sits beside the processor on the CPU card. It takes three prioritised interrupt request lines from the backplane, filters them through a two-bit level mask, and captures the highest enabled pending level on the falling edge of a synchronisation strobe. Once a level is captured, the block does three things:

- it raises the interrupt line to the processor;
- it drives the acknowledge line for that level back onto the bus;
- during the processor's interrupt-acknowledge cycle it supplies a one-byte restart opcode of the form 11AAA111, where AAA identifies the captured level.

Software programs the mask by writing to the identification port, which is the port whose low address byte is all ones. Software reads the same port to identify the interrupting device. While that read is active, the block asserts the outgoing grant into the device daisy chain. When the read finishes, the block releases the captured level.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset:
  - the interrupt line, all acknowledge lines, the grant and the opcode output are 0;
  - the mask holds code 11, so all levels are disabled.
- R2: The identification port is hit when `io_addr_lo` is 8'hFF and either `io_native` is 1 or `io_addr_hi` is 8'hFF. When `io_native` is 1, the upper byte is ignored.
- R3: When `io_wr` is 1 during a clock cycle in which the port is hit, `wr_data[1:0]` is stored as the mask. A write that does not hit the port leaves the mask unchanged.
- R4: Mask code 00 enables levels 1, 2 and 3. Code 01 enables levels 2 and 3. Code 10 enables level 3 only. Code 11 enables none. Level n is request bit `irq_req[n-1]`.
- R5: A strobe fall is a clock cycle in which `sync_n` is 0 after it was 1 in the previous cycle. On a strobe fall with at least one enabled request pending, the highest enabled level is captured. From the next cycle onward, `cpu_int` is 1 and `irq_ack[n-1]` is the only acknowledge bit set.
- R6: Nothing is captured in any of these cases:
  - no enabled request is pending at the strobe fall;
  - `sync_n` stays at one level, whether high or low;
  - requests change without a strobe fall.
- R7: While a level is captured, further strobe falls and request changes do not alter the captured level or the acknowledge lines.
- R8: While a level is captured and `inta_cycle` is 1, `opcode` is 8'hCF for level 1, 8'hD7 for level 2 and 8'hDF for level 3. At all other times `opcode` is 0.
- R9: `grant_out` equals `io_rd` AND port hit, with no clock delay.
- R10: Once a read that hits the port has ended, the captured level is released. Port hit and read both being 1 in one cycle and not in the next marks the end of the read. In the cycle after that, `cpu_int` and `irq_ack` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr_lo | input | 8 | Low address byte |
| io_addr_hi | input | 8 | High address byte (undriven during native I/O) |
| io_native | input | 1 | 1 when the cycle is a native I/O instruction |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| wr_data | input | 2 | Low data bits carrying the mask code |
| irq_req | input | 3 | Request per level, bit 0 = level 1 |
| sync_n | input | 1 | Active-low synchronisation strobe |
| inta_cycle | input | 1 | Processor is in its interrupt-acknowledge cycle |
| irq_ack | output | 3 | Acknowledge per level, one-hot while captured |
| cpu_int | output | 1 | Interrupt to the processor |
| opcode | output | 8 | Restart opcode during acknowledge |
| grant_out | output | 1 | Outgoing daisy-chain grant |

## Verification
The hardest state to reach is a captured level that must not move. A strobe fall and a higher-priority request have to arrive while a lower level is already held and before the identification read releases it. The bench first captures level 1 alone under mask 00. It then raises all three requests and issues a fresh strobe, and checks that the acknowledge line and the opcode still name level 1. The page-decode cases are also hard to reach from the ports, because the mask cannot be read back. A rejected write is therefore shown by a later strobe that still yields no interrupt.

// File: rtl/irqc_pkg.sv
// Package: shared constants and the restart opcode builder for the
// three-level interrupt controller. Assumes levels are coded 1..3, with 0 = none.
package irqc_pkg;
    localparam int LVL_N   = 3;
    localparam int ADDR_W  = 8;
    localparam int MASK_W  = 2;
    localparam int OP_W    = 8;
    localparam int CODE_W  = 2;
    localparam logic [ADDR_W-1:0] ID_PORT = '1;

    // Build the 11AAA111 restart opcode for a level code.
    function automatic logic [OP_W-1:0] restart_op(input logic [CODE_W-1:0] code);
        return {2'b11, 1'b0, code, 3'b111};
    endfunction
endpackage

// File: rtl/irqc_port_decode.sv
// Port decode and mask register. Recognises the identification port,
// stores the level mask on writes, and flags the end of an identification
// read. Assumes the upper address byte is undriven during native I/O.
module irqc_port_decode
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_lo,
    input  logic [ADDR_W-1:0] addr_hi,
    input  logic              native,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [MASK_W-1:0] wr_data,
    output logic              hit,
    output logic [MASK_W-1:0] mask,
    output logic              rd_done
);
    logic rd_q;
    logic rd_now;

    // Port hit: low byte all ones, page check only for memory-mapped cycles.
    always_comb begin
        hit    = (addr_lo == ID_PORT) && (native || (addr_hi == ID_PORT));
        rd_now = io_rd && hit;
    end

    // Mask register, reset to all levels disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)             mask <= '1;
        else if (io_wr && hit)  mask <= wr_data;
    end

    // Remember an identification read to detect its end.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= rd_now;
    end

    // End of the identification read.
    always_comb rd_done = rd_q && !rd_now;

    AST_MASK_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && hit) |=> $stable(mask)); // R3
endmodule

// File: rtl/irqc_level_latch.sv
// Level mask, priority select and capture latch. Captures the highest
// enabled pending level on a strobe fall and holds it until release.
// Assumes sync_n is already synchronous to clk.
module irqc_level_latch
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_n,
    input  logic [LVL_N-1:0]  req,
    input  logic [MASK_W-1:0] mask,
    input  logic              release_i,
    output logic              held,
    output logic [CODE_W-1:0] code,
    output logic [LVL_N-1:0]  ack
);
    logic [LVL_N-1:0]  en;
    logic [LVL_N-1:0]  cand;
    logic [CODE_W-1:0] pick;
    logic              sync_q;
    logic              fall;

    // Cumulative enable: level index i is enabled when i >= mask code.
    for (genvar i = 0; i < LVL_N; i++) begin : g_en
        assign en[i] = (i >= int'(mask));
    end

    // Priority select: the highest enabled pending level wins.
    always_comb begin
        cand = req & en;
        pick = '0;
        for (int i = 0; i < LVL_N; i++)
            if (cand[i]) pick = CODE_W'(i + 1);
        fall = sync_q && !sync_n;
    end

    // Strobe history and capture/hold/release of the level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b1;
            held   <= 1'b0;
            code   <= '0;
        end else begin
            sync_q <= sync_n;
            if (held && release_i) begin
                held <= 1'b0;
                code <= '0;
            end else if (!held && fall && (pick != '0)) begin
                held <= 1'b1;
                code <= pick;
            end
        end
    end

    // Acknowledge per level, driven from the captured code.
    for (genvar i = 0; i < LVL_N; i++) begin : g_ack
        assign ack[i] = held && (code == CODE_W'(i + 1));
    end

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> $onehot(ack)); // R5
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !release_i) |=> (held && $stable(code))); // R7
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (held && release_i) |=> !held); // R10
    AST_NO_CAPTURE_WITHOUT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && !fall) |=> !held); // R6
endmodule

// File: rtl/irqc_opcode_gen.sv
// Restart opcode driver for the acknowledge cycle. Assumes the code is
// nonzero whenever held is set.
module irqc_opcode_gen
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              held,
    input  logic              inta,
    input  logic [CODE_W-1:0] code,
    output logic [OP_W-1:0]   opcode
);
    // Drive the opcode only in an acknowledge cycle with a captured level.
    always_comb opcode = (held && inta) ? restart_op(code) : '0;

    AST_OPCODE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode != '0) |-> (opcode[7:6] == 2'b11 && opcode[2:0] == 3'b111)); // R8
endmodule

// File: rtl/irq_level_ctrl.sv
// Top of the three-level interrupt controller. Connects the port decode,
// the level latch and the opcode driver, and forms the daisy-chain grant.
// Assumes all inputs are synchronous to clk.
module irq_level_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr_lo,
    input  logic [ADDR_W-1:0] io_addr_hi,
    input  logic              io_native,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [MASK_W-1:0] wr_data,
    input  logic [LVL_N-1:0]  irq_req,
    input  logic              sync_n,
    input  logic              inta_cycle,
    output logic [LVL_N-1:0]  irq_ack,
    output logic              cpu_int,
    output logic [OP_W-1:0]   opcode,
    output logic              grant_out
);
    logic              hit;
    logic              rd_done;
    logic              held;
    logic [MASK_W-1:0] mask;
    logic [CODE_W-1:0] code;

    irqc_port_decode u_dec (
        .clk(clk), .rst_n(rst_n), .addr_lo(io_addr_lo), .addr_hi(io_addr_hi),
        .native(io_native), .io_wr(io_wr), .io_rd(io_rd), .wr_data(wr_data),
        .hit(hit), .mask(mask), .rd_done(rd_done)
    );

    irqc_level_latch u_lat (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .req(irq_req), .mask(mask),
        .release_i(rd_done), .held(held), .code(code), .ack(irq_ack)
    );

    irqc_opcode_gen u_op (
        .clk(clk), .rst_n(rst_n), .held(held), .inta(inta_cycle),
        .code(code), .opcode(opcode)
    );

    // Interrupt line and the read-fired grant.
    always_comb begin
        cpu_int   = held;
        grant_out = io_rd && hit;
    end

    AST_GRANT_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        grant_out |-> io_rd); // R9
    AST_INT_HAS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_int |-> ($countones(irq_ack) == 1)); // R5
endmodule

// File: tb/irq_level_ctrl_tb.sv
module irq_level_ctrl_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [7:0] io_addr_lo = 0, io_addr_hi = 0;
    logic       io_native = 0, io_wr = 0, io_rd = 0;
    logic [1:0] wr_data = 0;
    logic [2:0] irq_req = 0;
    logic       sync_n = 1, inta_cycle = 0;
    logic [2:0] irq_ack;
    logic       cpu_int, grant_out;
    logic [7:0] opcode;
    int n_checks = 0, n_fail = 0;

    always #10 clk = ~clk;

    irq_level_ctrl u_dut (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_mask(input logic [1:0] m, input logic [7:0] lo,
                           input logic [7:0] hi, input logic nat);
        @(negedge clk);
        io_addr_lo = lo; io_addr_hi = hi; io_native = nat; wr_data = m; io_wr = 1;
        @(negedge clk);
        io_wr = 0; io_addr_lo = 0; io_addr_hi = 0;
    endtask

    task automatic strobe();
        @(negedge clk); sync_n = 0;
        @(negedge clk); sync_n = 1;
    endtask

    // Checks interrupt, acknowledge and opcode after a capture.
    task automatic expect_lvl(input int lvl, input string tag);
        logic [2:0] ea;
        logic [7:0] eo;
        ea = (lvl == 0) ? 3'b000 : 3'(1 << (lvl - 1));
        eo = (lvl == 1) ? 8'hCF : (lvl == 2) ? 8'hD7 : (lvl == 3) ? 8'hDF : 8'h00;
        check(cpu_int == (lvl != 0), {tag, " int"}, int'(cpu_int), int'(lvl != 0));
        check(irq_ack == ea, {tag, " ack"}, int'(irq_ack), int'(ea));
        inta_cycle = 1; #1;
        check(opcode == eo, {tag, " R8 opcode"}, int'(opcode), int'(eo));
        inta_cycle = 0; #1;
        check(opcode == 8'h00, "R8 opcode idle", int'(opcode), 0);
    endtask

    task automatic id_read();
        @(negedge clk);
        io_addr_lo = 8'hFF; io_native = 1; io_rd = 1; #1;
        check(grant_out == 1, "R9 grant on id read", int'(grant_out), 1);
        @(negedge clk);
        check(cpu_int == held_exp, "R10 held during read", int'(cpu_int), int'(held_exp));
        io_rd = 0; io_addr_lo = 0; #1;
        check(grant_out == 0, "R9 grant drops", int'(grant_out), 0);
        @(negedge clk);
        check(cpu_int == 0 && irq_ack == 0, "R10 released", int'(cpu_int), 0);
    endtask
    logic held_exp = 0;

    task automatic t_reset();
        check(cpu_int == 0 && irq_ack == 0 && grant_out == 0, "R1 reset outputs",
              int'({cpu_int, irq_ack, grant_out}), 0);
        inta_cycle = 1; #1;
        check(opcode == 0, "R1 reset opcode", int'(opcode), 0);
        inta_cycle = 0;
        irq_req = 3'b111; strobe();
        expect_lvl(0, "R1 mask 11 after reset");
    endtask

    task automatic t_priority();
        wr_mask(2'b00, 8'hFF, 8'hFF, 0);
        irq_req = 3'b111; strobe(); expect_lvl(3, "R5 all pending");
        held_exp = 1; id_read();
        irq_req = 3'b011; strobe(); expect_lvl(2, "R5 levels 1,2");
        id_read();
        irq_req = 3'b001; strobe(); expect_lvl(1, "R5 level 1");
        id_read(); held_exp = 0;
    endtask

    task automatic t_masks();
        wr_mask(2'b01, 8'hFF, 8'hFF, 0);
        irq_req = 3'b001; strobe(); expect_lvl(0, "R4 mask01 blocks 1");
        irq_req = 3'b011; strobe(); expect_lvl(2, "R4 mask01 level 2");
        held_exp = 1; id_read();
        wr_mask(2'b10, 8'hFF, 8'hFF, 0);
        irq_req = 3'b011; strobe(); expect_lvl(0, "R4 mask10 blocks 1,2");
        irq_req = 3'b111; strobe(); expect_lvl(3, "R4 mask10 level 3");
        id_read(); held_exp = 0;
        wr_mask(2'b11, 8'hFF, 8'hFF, 0);
        irq_req = 3'b111; strobe(); expect_lvl(0, "R4 mask11 none");
    endtask

    task automatic t_hold();
        wr_mask(2'b00, 8'hFF, 8'hFF, 0);
        irq_req = 3'b001; strobe(); expect_lvl(1, "R7 first capture");
        irq_req = 3'b111; strobe(); expect_lvl(1, "R7 held against new strobe");
        held_exp = 1; id_read(); held_exp = 0;
    endtask

    task automatic t_no_edge();
        irq_req = 3'b000; strobe(); expect_lvl(0, "R6 nothing pending");
        irq_req = 3'b111;
        repeat (3) @(negedge clk);
        expect_lvl(0, "R6 requests without strobe");
        @(negedge clk); sync_n = 0; irq_req = 3'b000;
        @(negedge clk); irq_req = 3'b100;
        repeat (3) @(negedge clk);
        expect_lvl(0, "R6 strobe held low");
        sync_n = 1;
    endtask

    task automatic t_page();
        wr_mask(2'b11, 8'hFF, 8'hFF, 0);
        wr_mask(2'b00, 8'hFF, 8'h12, 0);
        irq_req = 3'b111; strobe(); expect_lvl(0, "R2 mem-mapped wrong page");
        wr_mask(2'b00, 8'hFE, 8'hFF, 1);
        strobe(); expect_lvl(0, "R3 wrong low byte");
        wr_mask(2'b00, 8'hFF, 8'h12, 1);
        strobe(); expect_lvl(3, "R2 native ignores upper byte");
        @(negedge clk);
        io_addr_lo = 8'hFF; io_addr_hi = 8'h12; io_native = 0; io_rd = 1; #1;
        check(grant_out == 0, "R9 no grant off page", int'(grant_out), 0);
        @(negedge clk); io_rd = 0;
        @(negedge clk);
        check(cpu_int == 1, "R10 off-page read keeps level", int'(cpu_int), 1);
        held_exp = 1; id_read(); held_exp = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_priority();
        t_masks();
        t_hold();
        t_no_edge();
        t_page();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule